// File: doc/BRIEF.md
# Security-Banked Interrupt Acknowledge Unit

This block sits on the processor side of an interrupt controller. It keeps a pending bit and an active bit for each interrupt source. Each source has its own 8-bit priority and a group bit. Every cycle it picks the most urgent pending source. When software reads an acknowledge port, the block decides what to return from three things: the winner's group, the security state of the request, and the port that was read. The result is either the winner's interrupt ID or a special ID. When the result is a real ID, that read is also the acknowledge: the source moves from pending to active. Software later writes the same ID to the end-of-interrupt port, which releases the active state.

In the default (legacy) mode, port A is the primary acknowledge register and port B is its alias. A secure read of the alias gives exactly the answer a non-secure read of port A would give. This lets secure software take group 1 interrupts. When `split_mode` is high, port A acknowledges only group 0 and port B only group 1. In that mode there is no alias, and the "nothing for you" answer depends on the requester's security state.

Top module: `irq_ack_unit`

## Requirements
- R1: After reset no source is pending or active, `rd_done` is 0 and `rd_id` is 1023.
- R2: A source whose level input is sampled high while it is not active becomes pending and stays pending until it is acknowledged. A high level on a source that is active does not make it pending.
- R3: The winner is the pending source with the numerically smallest priority. When priorities are equal, the lower ID wins.
- R4: In legacy mode, a secure read of port A with a group 0 winner, or a non-secure read of port A with a group 1 winner, returns the winner's ID and acknowledges it.
- R5: In legacy mode, a non-secure read of port A with a group 0 winner returns 1023 and changes no pending or active bit.
- R6: In legacy mode, a secure read of port A with a group 1 winner returns 1022 without acknowledging when `ack_ctl` is 0. When `ack_ctl` is 1, it returns the winner's ID and acknowledges it.
- R7: In legacy mode, a secure read of port B (the alias) behaves exactly like a non-secure read of port A. A non-secure read of port B returns 1023 and acknowledges nothing.
- R8: An acknowledge clears the source's pending bit and sets its active bit on the same edge. That ID is not returned again until an end-of-interrupt for it is written and the source is raised again.
- R9: In split mode, port A returns the winner's ID only for a secure read with a group 0 winner. Port B returns the winner's ID only for a group 1 winner, for either security state. Every other case returns 1023 and acknowledges nothing.
- R10: With no source pending, every read of either port in either mode returns 1023.
- R11: Writing an ID below the source count to the end-of-interrupt port clears that source's active bit. Writes of IDs 1020 to 1023 are ignored.
- R12: `rd_id` and `rd_done` are registered. They answer a read request one clock after `rd_valid` is sampled, and `rd_done` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_level | input | NUM_SRC | Level inputs, sampled each clock |
| src_prio | input | NUM_SRC*PRIO_W | Priority per source; source i uses bits [i*PRIO_W +: PRIO_W], and a smaller value is more urgent |
| src_group | input | NUM_SRC | Group per source (0 = group 0, 1 = group 1) |
| ack_ctl | input | 1 | Lets a secure legacy port A read take group 1 |
| split_mode | input | 1 | 0 = primary/alias ports, 1 = per-group ports |
| rd_valid | input | 1 | Acknowledge read request |
| rd_port | input | 1 | 0 = port A, 1 = port B |
| rd_sec | input | 1 | 1 = secure requester |
| rd_id | output | 10 | Returned ID, registered |
| rd_done | output | 1 | One-cycle response strobe |
| eoi_valid | input | 1 | End-of-interrupt write strobe |
| eoi_id | input | 10 | ID being completed |

## Verification
A read request is sampled on a clock edge, and its `rd_id` and `rd_done` appear right after that same edge. The pending and active changes caused by the read also take effect on that edge. A level input or end-of-interrupt written before edge k is first visible to a read sampled on edge k+1. The bench drives every input at the falling edge and compares 1 ns after the rising edge. Its reference model is advanced once per rising edge. Sweeps cover all combinations of mode, port, security and `ack_ctl` over many priority and group patterns, and directed cases cover ties, re-raising an active source and ignored special end-of-interrupt writes.

// File: rtl/irq_ack_pkg.sv
// Package: shared constants and types for the interrupt acknowledge unit.
// Assumes returned IDs are 10 bits wide and the top 4 codes are reserved.
package irq_ack_pkg;
    localparam int ID_W = 10;
    localparam logic [ID_W-1:0] ID_NONE      = 10'd1023;
    localparam logic [ID_W-1:0] ID_OTHER_GRP = 10'd1022;
    localparam logic [ID_W-1:0] ID_RSVD_LO   = 10'd1020;

    typedef struct packed {
        logic            found;
        logic            grp;
        logic [ID_W-1:0] id;
    } winner_t;
endpackage

// File: rtl/irq_pend_bank.sv
// Pending/active state per source.
// Assumes ack_mask and eoi_mask carry at most one bit each; ack wins over eoi.
module irq_pend_bank #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_level,
    input  logic [NUM_SRC-1:0] ack_mask,
    input  logic [NUM_SRC-1:0] eoi_mask,
    output logic [NUM_SRC-1:0] pend_q,
    output logic [NUM_SRC-1:0] act_q
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        // Update one source's pending and active flags.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[i] <= 1'b0;
                act_q[i]  <= 1'b0;
            end else begin
                pend_q[i] <= ack_mask[i] ? 1'b0 : (pend_q[i] | (src_level[i] & ~act_q[i]));
                act_q[i]  <= ack_mask[i] | (act_q[i] & ~eoi_mask[i]);
            end
        end
    end

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_mask)); // R8
    AST_NO_PEND_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & act_q) == '0); // R2
endmodule

// File: rtl/irq_prio_pick.sv
// Finds the pending source with the smallest priority value; ties go to
// the lower index. Purely combinational, linear scan over the sources.
module irq_prio_pick
    import irq_ack_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 8
) (
    input  logic [NUM_SRC-1:0]        pend,
    input  logic [NUM_SRC*PRIO_W-1:0] prio,
    input  logic [NUM_SRC-1:0]        grp,
    output winner_t                   win
);
    logic [PRIO_W-1:0] best;

    // Scan upward; strict less-than keeps the lowest index on a tie.
    always_comb begin
        win  = '0;
        best = '1;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend[i] && (!win.found || prio[i*PRIO_W +: PRIO_W] < best)) begin
                win.found = 1'b1;
                win.grp   = grp[i];
                win.id    = ID_W'(i);
                best      = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/irq_ack_decode.sv
// Decides the returned ID and whether a read acknowledges, from mode,
// port, requester security and the winner's group. Combinational.
module irq_ack_decode
    import irq_ack_pkg::*;
(
    input  winner_t         win,
    input  logic            split_mode,
    input  logic            ack_ctl,
    input  logic            rd_port,
    input  logic            rd_sec,
    output logic [ID_W-1:0] ret_id,
    output logic            grant
);
    logic eff_sec;

    // Legacy alias makes a secure request look non-secure.
    assign eff_sec = rd_port ? 1'b0 : rd_sec;

    // Select the answer for the current request.
    always_comb begin
        grant  = 1'b0;
        ret_id = ID_NONE;
        if (win.found) begin
            if (split_mode) begin
                grant = rd_port ? win.grp : (rd_sec & ~win.grp);
            end else if (rd_port && !rd_sec) begin
                grant = 1'b0;
            end else if (eff_sec && win.grp) begin
                grant = ack_ctl;
                if (!ack_ctl) ret_id = ID_OTHER_GRP;
            end else begin
                grant = eff_sec ^ win.grp;
            end
            if (grant) ret_id = win.id;
        end
    end
endmodule

// File: rtl/irq_ack_unit.sv
// Top: security-banked interrupt acknowledge unit. One read request per
// cycle; response registered one cycle later. Assumes NUM_SRC <= 1020 and
// software does not complete and acknowledge the same ID in one cycle.
module irq_ack_unit
    import irq_ack_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        src_level,
    input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
    input  logic [NUM_SRC-1:0]        src_group,
    input  logic                      ack_ctl,
    input  logic                      split_mode,
    input  logic                      rd_valid,
    input  logic                      rd_port,
    input  logic                      rd_sec,
    output logic [9:0]                rd_id,
    output logic                      rd_done,
    input  logic                      eoi_valid,
    input  logic [9:0]                eoi_id
);
    localparam int IDX_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] pend_q, act_q, ack_mask, eoi_mask;
    winner_t            win;
    logic [ID_W-1:0]    ret_id;
    logic               grant;

    irq_pend_bank #(.NUM_SRC(NUM_SRC)) i_bank (
        .clk(clk), .rst_n(rst_n), .src_level(src_level),
        .ack_mask(ack_mask), .eoi_mask(eoi_mask),
        .pend_q(pend_q), .act_q(act_q)
    );

    irq_prio_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) i_pick (
        .pend(pend_q), .prio(src_prio), .grp(src_group), .win(win)
    );

    irq_ack_decode i_dec (
        .win(win), .split_mode(split_mode), .ack_ctl(ack_ctl),
        .rd_port(rd_port), .rd_sec(rd_sec), .ret_id(ret_id), .grant(grant)
    );

    // Turn a granted read into a one-hot acknowledge.
    always_comb begin
        ack_mask = '0;
        if (rd_valid && grant) ack_mask[win.id[IDX_W-1:0]] = 1'b1;
    end

    // Decode end-of-interrupt writes, dropping reserved and unmapped IDs.
    always_comb begin
        eoi_mask = '0;
        if (eoi_valid && eoi_id < ID_RSVD_LO && eoi_id < ID_W'(NUM_SRC))
            eoi_mask[eoi_id[IDX_W-1:0]] = 1'b1;
    end

    // Register the read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_id   <= ID_NONE;
            rd_done <= 1'b0;
        end else begin
            rd_done <= rd_valid;
            if (rd_valid) rd_id <= ret_id;
        end
    end

    AST_EMPTY_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !win.found |=> rd_id == ID_NONE); // R10
    AST_NS_GRP0_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !split_mode && !rd_port && !rd_sec && win.found && !win.grp
        |=> rd_id == ID_NONE && $stable(pend_q)); // R5
    AST_SEC_GRP1_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !split_mode && !rd_port && rd_sec && win.found && win.grp && !ack_ctl
        |=> rd_id == ID_OTHER_GRP); // R6
    AST_SPLIT_G0_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && split_mode && !rd_port && win.found && (win.grp || !rd_sec)
        |=> rd_id == ID_NONE); // R9
    AST_ACK_MOVES_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done && rd_id < ID_RSVD_LO |-> act_q[rd_id[IDX_W-1:0]] && !pend_q[rd_id[IDX_W-1:0]]); // R8
    AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rd_done); // R12
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> !rd_done); // R12
endmodule

// File: tb/test_irq_ack_unit.sv
`timescale 1ns/1ps
module test_irq_ack_unit;
    localparam int N  = 32;
    localparam int PW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    src_level = '0;
    logic [N*PW-1:0] src_prio = '0;
    logic [N-1:0]    src_group = '0;
    logic            ack_ctl = 1'b0, split_mode = 1'b0;
    logic            rd_valid = 1'b0, rd_port = 1'b0, rd_sec = 1'b0;
    logic [9:0]      rd_id;
    logic            rd_done;
    logic            eoi_valid = 1'b0;
    logic [9:0]      eoi_id = '0;

    int n_cmp = 0, n_bad = 0;
    bit done_flag = 0;
    logic [N-1:0] pm = '0, am = '0;

    always #2 clk = ~clk;

    irq_ack_unit #(.NUM_SRC(N), .PRIO_W(PW)) i_irq_ack_unit (
        .clk(clk), .rst_n(rst_n), .src_level(src_level), .src_prio(src_prio),
        .src_group(src_group), .ack_ctl(ack_ctl), .split_mode(split_mode),
        .rd_valid(rd_valid), .rd_port(rd_port), .rd_sec(rd_sec),
        .rd_id(rd_id), .rd_done(rd_done), .eoi_valid(eoi_valid), .eoi_id(eoi_id)
    );

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference: expected answer of the current request from the model state.
    task automatic expect_read(output int id, output bit g, output string tag);
        bit f = 0, wg = 0, es;
        int wid = 0, best = 256;
        for (int i = 0; i < N; i++)
            if (pm[i] && int'(src_prio[i*PW +: PW]) < best) begin
                f = 1; wg = src_group[i]; wid = i; best = int'(src_prio[i*PW +: PW]);
            end
        g = 0; id = 1023; tag = "R10";
        if (f) begin
            if (split_mode) begin
                tag = "R9";
                g = rd_port ? wg : (rd_sec && !wg);
            end else if (rd_port && !rd_sec) begin
                tag = "R7";
            end else begin
                es = rd_port ? 1'b0 : rd_sec;
                tag = rd_port ? "R7" : (es && wg) ? "R6" : (!es && !wg) ? "R5" : "R4";
                if (es && wg) begin g = ack_ctl; if (!ack_ctl) id = 1022; end
                else g = es ^ wg;
            end
            if (g) id = wid;
        end
    endtask

    // One clock: predict, advance model on the edge, compare after it.
    task automatic step();
        int eid; bit eg; string etag; bit was_rd = rd_valid;
        expect_read(eid, eg, etag);
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            bit ak = was_rd && eg && eid == i;
            bit ek = eoi_valid && int'(eoi_id) == i;
            pm[i] = ak ? 1'b0 : (pm[i] | (src_level[i] & ~am[i]));
            am[i] = ak | (am[i] & ~ek);
        end
        #1;
        if (was_rd) begin
            check(etag, int'(rd_id), eid);
            check("R12", int'(rd_done), 1);
        end
        @(negedge clk);
    endtask

    task automatic rd(bit port, bit sec);
        rd_valid = 1; rd_port = port; rd_sec = sec;
        step();
        rd_valid = 0;
    endtask

    task automatic eoi(int id);
        eoi_valid = 1; eoi_id = 10'(id);
        step();
        eoi_valid = 0;
    endtask

    task automatic pulse(logic [N-1:0] m);
        src_level = m; step(); src_level = '0;
    endtask

    initial begin
        #400000;
        if (!done_flag) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #3;
        check("R1", int'(rd_id), 1023);
        check("R1", int'(rd_done), 0);
        @(negedge clk);
        rd(0, 1);
        check("R1", int'(rd_id), 1023);
        step();
        check("R12", int'(rd_done), 0);

        // Sweep patterns and every mode/port/security/ack_ctl combination.
        for (int p = 0; p < 12; p++) begin
            for (int i = 0; i < N; i++) begin
                src_prio[i*PW +: PW] = 8'((i * (p * 2 + 3) + p * 7) % (p < 4 ? 4 : 256));
                src_group[i] = 1'(((i * (p + 1)) >> 1) ^ p);
            end
            for (int i = 0; i < N; i++) src_level[i] = ((i * 7 + p * 3) % 5) != 0;
            step();
            src_level = '0;
            for (int r = 0; r < 2; r++)
                for (int c = 0; c < 16; c++) begin
                    split_mode = c[3]; ack_ctl = c[2];
                    rd(c[1], c[0]);
                end
            for (int i = 0; i < N; i++) if (am[i] && ((i + p) % 3 != 0)) eoi(i);
        end

        // Drain everything.
        split_mode = 1;
        while (pm != '0) begin rd(1, 0); rd(0, 1); end
        split_mode = 0; ack_ctl = 0;
        for (int i = 0; i < N; i++) if (am[i]) eoi(i);
        rd(1, 1);
        check("R10", int'(rd_id), 1023);

        // Tie: sources 9 and 5 share the best priority, group 0.
        for (int i = 0; i < N; i++) begin src_prio[i*PW +: PW] = 8'd200; src_group[i] = 1'b0; end
        src_prio[5*PW +: PW] = 8'd10; src_prio[9*PW +: PW] = 8'd10;
        pulse((N'(1) << 5) | (N'(1) << 9));
        rd(0, 0);
        check("R5", int'(rd_id), 1023);
        rd(0, 1);
        check("R3", int'(rd_id), 5);
        pulse(N'(1) << 5);
        rd(0, 1);
        check("R2", int'(rd_id), 9);
        rd(0, 1);
        check("R8", int'(rd_id), 1023);

        // Special end-of-interrupt IDs are ignored (1023 maps onto index 31).
        src_group[31] = 1'b1;
        pulse(N'(1) << 31);
        rd(0, 0);
        check("R4", int'(rd_id), 31);
        eoi(1023);
        eoi(1020);
        pulse(N'(1) << 31);
        rd(0, 0);
        check("R11", int'(rd_id), 1023);
        eoi(31);
        pulse(N'(1) << 31);
        rd(1, 1);
        check("R7", int'(rd_id), 31);
        eoi(31); eoi(5); eoi(9);
        pulse(N'(1) << 31);
        rd(0, 1);
        check("R6", int'(rd_id), 1022);
        ack_ctl = 1;
        rd(0, 1);
        check("R6", int'(rd_id), 31);
        step();
        check("R12", int'(rd_done), 0);

        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule